// File: doc/BRIEF.md
# Dual-Pool HDLC Receive FIFO Controller

This block sits between an HDLC deframer and a host processor on the receive side of a link. The deframer hands it one byte at a time, marks the final byte of each frame, and supplies three status bits with that final byte: CRC good, frame aborted, and receiver overflow. The controller stores the bytes in two pools of 32 bytes that it fills one after the other. Each filled pool is handed to the host through one of two interrupt lines.

A pool that fills while its frame is still running raises the pool-full request, and the host reads all 32 bytes. A pool that holds the end of a frame raises the message-end request. That request comes with a 5-bit residual byte count and a status byte. After reading, the host acknowledges, which returns the pool for reuse and brings forward the request for the other pool if that pool is waiting. A frame for which no free pool exists is discarded completely, and a one-cycle lost-frame flag is raised. Reception of later frames carries on normally.

Top module: `rx_pool_ctrl`

## Requirements
- R1: After reset both interrupt lines, `frame_lost`, `msg_count` and `msg_status` are 0.
- R2: A frame of 1 to 31 bytes raises `irq_msg_end` on the cycle after its last byte is accepted, with `msg_count` equal to the frame length.
- R3: A frame whose final pool holds exactly 32 bytes reports `msg_count` = 0 with `irq_msg_end`.
- R4: A frame longer than 32 bytes raises `irq_pool_full` for each full pool of 32 bytes once the next byte of the same frame arrives, and raises `irq_msg_end` for the remainder.
- R5: `msg_status` bit 0 is CRC good, bit 1 is abort and bit 2 is receiver overflow. All three are taken from the status inputs that come with the last byte. Bits 7..3 are 0.
- R6: At most one interrupt line is high at a time, and it always belongs to the oldest filled pool. The request for the other pool appears only after the acknowledge.
- R7: A frame whose first byte finds no free pool is discarded in full. `frame_lost` pulses high for one cycle after its last byte, and later frames are stored and reported normally.
- R8: An `ack` given while no interrupt is pending has no effect.
- R9: `rd_data` shows the byte at the host read position of the pending pool. Each `rd_en` advances that position by one, and the position starts at byte 0 of every pool presented.
- R10: `msg_count` and `msg_status` read 0 while `irq_msg_end` is low.
- R11: If a frame needs a new pool part way through and none is free, the part already in the current pool is discarded, the rest of the frame is dropped, and `frame_lost` pulses after its last byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Deframer byte strobe |
| in_data | input | 8 | Received byte |
| in_last | input | 1 | Marks the final byte of a frame |
| in_crc_ok | input | 1 | CRC good, sampled with the final byte |
| in_abort | input | 1 | Frame aborted, sampled with the final byte |
| in_ovf | input | 1 | Deframer overflow, sampled with the final byte |
| rd_en | input | 1 | Host read strobe, advances the read position |
| rd_data | output | 8 | Byte at the host read position |
| ack | input | 1 | Host acknowledge, releases the pending pool |
| irq_pool_full | output | 1 | Pending pool holds 32 bytes of an unfinished frame |
| irq_msg_end | output | 1 | Pending pool holds the end of a frame |
| msg_count | output | 5 | Residual byte count (0 means 32) |
| msg_status | output | 8 | Frame status byte |
| frame_lost | output | 1 | One-cycle pulse when a frame is discarded |

## Verification
The assertions check on every cycle that the two interrupt lines are never high together and that an acknowledge with nothing pending leaves the read pool unchanged. They also check that an accepted acknowledge moves the read side to the other pool, that the write fill level never goes past a pool's size, and that a lost-frame pulse follows only the last byte of a frame. Only the bench scenarios can show that the bytes come out in order, that the counts are right at the 31, 32, 33 and 64 byte boundaries, that the status bits land in the right positions, and that whole frames are dropped while later frames are still delivered.

// File: rtl/rxp_pkg.sv
// Shared types for the dual-pool receive controller.
// Assumes exactly two pools; pool index is a single bit.
package rxp_pkg;
    typedef enum logic [1:0] {
        PS_FREE = 2'd0,   // empty, available to the writer
        PS_FILL = 2'd1,   // being written by the current frame
        PS_FULL = 2'd2,   // 32 bytes of an unfinished frame, awaiting host
        PS_END  = 2'd3    // holds the end of a frame, awaiting host
    } pool_st_e;

    localparam int STAT_W = 8;
endpackage

// File: rtl/rxp_pool_mem.sv
// Two-pool byte storage: one synchronous write port, one combinational read port.
// Assumes DEPTH is a power of two; the pool index forms the top address bit.
module rxp_pool_mem #(
    parameter int DATA_W = 8,
    parameter int DEPTH  = 32,
    localparam int AW    = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              we,
    input  logic              wpool,
    input  logic [AW-1:0]     waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              rpool,
    input  logic [AW-1:0]     raddr,
    output logic [DATA_W-1:0] rdata
);
    logic [DATA_W-1:0] store [2*DEPTH];

    // Write one byte into the selected pool slot.
    always_ff @(posedge clk) begin
        if (we) begin
            store[{wpool, waddr}] <= wdata;
        end
    end

    // Present the byte at the host read position.
    always_comb begin
        rdata = store[{rpool, raddr}];
    end
endmodule

// File: rtl/rxp_host_port.sv
// Host side: tracks the oldest filled pool, raises its interrupt, walks the
// read position on rd_en and releases the pool on an accepted acknowledge.
// Assumes the writer fills pools in strict alternation.
module rxp_host_port #(
    parameter int DEPTH  = 32,
    parameter int STAT_W = 8,
    localparam int AW    = $clog2(DEPTH)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [1:0]             full_vec,
    input  logic [1:0]             end_vec,
    input  logic [1:0][AW-1:0]     end_cnt,
    input  logic [1:0][STAT_W-1:0] end_stat,
    input  logic                   rd_en,
    input  logic                   ack,
    output logic                   rd_pool,
    output logic [AW-1:0]          rd_idx,
    output logic                   ack_take,
    output logic                   irq_pool_full,
    output logic                   irq_msg_end,
    output logic [AW-1:0]          msg_count,
    output logic [STAT_W-1:0]      msg_status
);
    logic pending;

    // Decode the request of the oldest pool and qualify the acknowledge.
    always_comb begin
        irq_pool_full = full_vec[rd_pool];
        irq_msg_end   = end_vec[rd_pool];
        pending       = irq_pool_full | irq_msg_end;
        ack_take      = ack & pending;
        msg_count     = irq_msg_end ? end_cnt[rd_pool]  : '0;
        msg_status    = irq_msg_end ? end_stat[rd_pool] : '0;
    end

    // Advance the read position and switch pools on an accepted acknowledge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_pool <= 1'b0;
            rd_idx  <= '0;
        end else if (ack_take) begin
            rd_pool <= ~rd_pool;
            rd_idx  <= '0;
        end else if (rd_en && pending) begin
            rd_idx  <= rd_idx + 1'b1;
        end
    end

    a_r6_one_irq: assert property (@(posedge clk) disable iff (!rst_n)
        !(irq_pool_full && irq_msg_end));

    a_r8_ack_idle_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && !irq_pool_full && !irq_msg_end) |=> $stable(rd_pool));

    a_r6_ack_moves_pool: assert property (@(posedge clk) disable iff (!rst_n)
        ack_take |=> (rd_pool != $past(rd_pool)) && (rd_idx == '0));
endmodule

// File: rtl/rx_pool_ctrl.sv
// Dual-pool receive controller top: write-side pool bookkeeping, frame drop
// handling, storage and host port. A pool that reaches DEPTH bytes stays in
// fill state until the frame's next byte shows whether the frame continues.
// Assumes in_valid bytes belong to consecutive frames each closed by in_last.
module rx_pool_ctrl #(
    parameter int DATA_W = 8,
    parameter int DEPTH  = 32,
    localparam int AW    = $clog2(DEPTH),
    localparam int CW    = AW + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] in_data,
    input  logic              in_last,
    input  logic              in_crc_ok,
    input  logic              in_abort,
    input  logic              in_ovf,
    input  logic              rd_en,
    output logic [DATA_W-1:0] rd_data,
    input  logic              ack,
    output logic              irq_pool_full,
    output logic              irq_msg_end,
    output logic [AW-1:0]     msg_count,
    output logic [7:0]        msg_status,
    output logic              frame_lost
);
    import rxp_pkg::*;

    localparam logic [CW-1:0] FULL_LVL = CW'(DEPTH);

    pool_st_e                  pst [2];
    logic                      wr_pool;
    logic [CW-1:0]             wcnt;
    logic                      dropping;
    logic [1:0][AW-1:0]        end_cnt;
    logic [1:0][STAT_W-1:0]    end_stat;
    logic [1:0]                full_vec, end_vec;
    logic                      rd_pool, ack_take;
    logic [AW-1:0]             rd_idx;

    logic                      at_full, other_free, cur_free;
    logic                      do_switch, no_space, do_plain, mem_we;
    logic [STAT_W-1:0]         stat_in;
    logic [CW-1:0]             wcnt_inc;

    // Classify the incoming byte against the pool states.
    always_comb begin
        at_full    = (wcnt == FULL_LVL);
        other_free = (pst[~wr_pool] == PS_FREE);
        cur_free   = (pst[wr_pool] == PS_FREE);
        do_switch  = in_valid && !dropping && at_full && other_free;
        no_space   = in_valid && !dropping &&
                     ((at_full && !other_free) || (wcnt == '0 && !cur_free));
        do_plain   = in_valid && !dropping && !at_full && !no_space;
        mem_we     = do_switch || do_plain;
        stat_in    = {{(STAT_W-3){1'b0}}, in_ovf, in_abort, in_crc_ok};
        wcnt_inc   = wcnt + 1'b1;
    end

    // Export ready flags of both pools to the host port.
    always_comb begin
        for (int p = 0; p < 2; p++) begin
            full_vec[p] = (pst[p] == PS_FULL);
            end_vec[p]  = (pst[p] == PS_END);
        end
    end

    // Write-side state: pool ownership, fill level, drop mode, end reports.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pst[0]     <= PS_FREE;
            pst[1]     <= PS_FREE;
            wr_pool    <= 1'b0;
            wcnt       <= '0;
            dropping   <= 1'b0;
            end_cnt    <= '0;
            end_stat   <= '0;
            frame_lost <= 1'b0;
        end else begin
            frame_lost <= 1'b0;
            if (ack_take) begin
                pst[rd_pool] <= PS_FREE;
            end
            if (in_valid && dropping) begin
                if (in_last) begin
                    dropping   <= 1'b0;
                    frame_lost <= 1'b1;
                end
            end else if (no_space) begin
                if (at_full) begin
                    pst[wr_pool] <= PS_FREE;
                end
                wcnt <= '0;
                if (in_last) begin
                    frame_lost <= 1'b1;
                end else begin
                    dropping <= 1'b1;
                end
            end else if (do_switch) begin
                pst[wr_pool] <= PS_FULL;
                if (in_last) begin
                    pst[~wr_pool]      <= PS_END;
                    end_cnt[~wr_pool]  <= AW'(1);
                    end_stat[~wr_pool] <= stat_in;
                    wcnt               <= '0;
                end else begin
                    pst[~wr_pool] <= PS_FILL;
                    wr_pool       <= ~wr_pool;
                    wcnt          <= CW'(1);
                end
            end else if (do_plain) begin
                if (in_last) begin
                    pst[wr_pool]      <= PS_END;
                    end_cnt[wr_pool]  <= wcnt_inc[AW-1:0];
                    end_stat[wr_pool] <= stat_in;
                    wr_pool           <= ~wr_pool;
                    wcnt              <= '0;
                end else begin
                    pst[wr_pool] <= PS_FILL;
                    wcnt         <= wcnt_inc;
                end
            end
        end
    end

    rxp_pool_mem #(
        .DATA_W (DATA_W),
        .DEPTH  (DEPTH)
    ) u_mem (
        .clk   (clk),
        .we    (mem_we),
        .wpool (do_switch ? ~wr_pool : wr_pool),
        .waddr (do_switch ? '0 : wcnt[AW-1:0]),
        .wdata (in_data),
        .rpool (rd_pool),
        .raddr (rd_idx),
        .rdata (rd_data)
    );

    rxp_host_port #(
        .DEPTH  (DEPTH),
        .STAT_W (STAT_W)
    ) u_host (
        .clk           (clk),
        .rst_n         (rst_n),
        .full_vec      (full_vec),
        .end_vec       (end_vec),
        .end_cnt       (end_cnt),
        .end_stat      (end_stat),
        .rd_en         (rd_en),
        .ack           (ack),
        .rd_pool       (rd_pool),
        .rd_idx        (rd_idx),
        .ack_take      (ack_take),
        .irq_pool_full (irq_pool_full),
        .irq_msg_end   (irq_msg_end),
        .msg_count     (msg_count),
        .msg_status    (msg_status)
    );

    a_r4_fill_bound: assert property (@(posedge clk) disable iff (!rst_n)
        wcnt <= FULL_LVL);

    a_r6_writer_owns_fill: assert property (@(posedge clk) disable iff (!rst_n)
        (pst[wr_pool] == PS_FULL || pst[wr_pool] == PS_END) |-> (wcnt == '0));

    a_r7_lost_after_last: assert property (@(posedge clk) disable iff (!rst_n)
        frame_lost |-> $past(in_valid && in_last));
endmodule

// File: tb/rx_pool_ctrl_tb.sv
`timescale 1ns/1ps
module rx_pool_ctrl_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       in_valid = 1'b0, in_last = 1'b0;
    logic [7:0] in_data = '0;
    logic       in_crc_ok = 1'b0, in_abort = 1'b0, in_ovf = 1'b0;
    logic       rd_en = 1'b0, ack = 1'b0;
    logic [7:0] rd_data;
    logic       irq_pool_full, irq_msg_end, frame_lost;
    logic [4:0] msg_count;
    logic [7:0] msg_status;

    int errors = 0;
    int checks = 0;
    logic [7:0] fbuf [4][128];

    always #5 clk = ~clk;

    rx_pool_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
        .in_last(in_last), .in_crc_ok(in_crc_ok), .in_abort(in_abort),
        .in_ovf(in_ovf), .rd_en(rd_en), .rd_data(rd_data), .ack(ack),
        .irq_pool_full(irq_pool_full), .irq_msg_end(irq_msg_end),
        .msg_count(msg_count), .msg_status(msg_status), .frame_lost(frame_lost)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Expected residual count for a final pool of n bytes (R2/R3).
    function automatic int exp_count(input int n);
        return n % 32;
    endfunction

    // Expected status byte from the three deframer bits (R5).
    function automatic int exp_status(input logic [2:0] st);
        return {5'b0, st[2], st[1], st[0]};
    endfunction

    task automatic send_frame(input int slot, input int len, input logic [2:0] st,
                              output bit lost);
        for (int i = 0; i < len; i++) begin
            fbuf[slot][i] = 8'($urandom);
            in_valid  = 1'b1;
            in_data   = fbuf[slot][i];
            in_last   = (i == len - 1);
            in_crc_ok = (i == len - 1) ? st[0] : 1'($urandom);
            in_abort  = (i == len - 1) ? st[1] : 1'($urandom);
            in_ovf    = (i == len - 1) ? st[2] : 1'($urandom);
            @(negedge clk);
        end
        in_valid = 1'b0;
        in_last  = 1'b0;
        lost     = frame_lost;
    endtask

    task automatic no_irq(input string tag);
        chk(!irq_pool_full && !irq_msg_end, tag, {irq_pool_full, irq_msg_end}, 0);
    endtask

    task automatic drain(input int slot, input int len, input logic [2:0] st);
        int rem = len;
        int pos = 0;
        while (rem > 0) begin
            int  n;
            bit  fin;
            fin = (rem <= 32);
            n   = fin ? rem : 32;
            chk(irq_pool_full == !fin, "R4 pool-full line", irq_pool_full, !fin);
            chk(irq_msg_end == fin, "R2 msg-end line", irq_msg_end, fin);
            if (fin) begin
                chk(msg_count == exp_count(n), (n == 32) ? "R3 count of full final pool" : "R2 residual count",
                    msg_count, exp_count(n));
                chk(msg_status == exp_status(st), "R5 status byte", msg_status, exp_status(st));
            end else begin
                chk(msg_count == 0 && msg_status == 0, "R10 count/status zero without msg-end",
                    {msg_count, msg_status}, 0);
            end
            for (int i = 0; i < n; i++) begin
                chk(rd_data == fbuf[slot][pos + i], "R9 read data order", rd_data, fbuf[slot][pos + i]);
                rd_en = 1'b1;
                @(negedge clk);
            end
            rd_en = 1'b0;
            ack   = 1'b1;
            @(negedge clk);
            ack   = 1'b0;
            rem  -= n;
            pos  += n;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        bit lost;
        int seed;
        seed = $urandom(32'd4711);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk(!irq_pool_full && !irq_msg_end && !frame_lost, "R1 reset lines",
            {irq_pool_full, irq_msg_end, frame_lost}, 0);
        chk(msg_count == 0 && msg_status == 0, "R1 reset count/status", {msg_count, msg_status}, 0);

        // R8: acknowledge with nothing pending, then a normal frame must still report
        ack = 1'b1; @(negedge clk); ack = 1'b0;
        no_irq("R8 idle ack raises nothing");
        send_frame(0, 5, 3'b001, lost);
        chk(!lost, "R8 no loss after idle ack", lost, 0);
        drain(0, 5, 3'b001);

        // Boundary lengths: R2 (31), R3 (32), R4 (33, 64)
        send_frame(0, 31, 3'b010, lost); drain(0, 31, 3'b010);
        send_frame(0, 32, 3'b100, lost); drain(0, 32, 3'b100);
        send_frame(0, 33, 3'b111, lost); drain(0, 33, 3'b111);
        send_frame(0, 64, 3'b001, lost); drain(0, 64, 3'b001);
        chk(!lost, "R4 no loss on two-pool frame", lost, 0);

        // R6: two frames queued, only the oldest reported until ack
        send_frame(0, 10, 3'b001, lost);
        send_frame(1, 20, 3'b110, lost);
        chk(msg_count == 10, "R6 oldest pool first", msg_count, 10);
        drain(0, 10, 3'b001);
        drain(1, 20, 3'b110);
        no_irq("R6 nothing after both drained");

        // R7: both pools busy, third frame dropped, later frame fine
        send_frame(0, 10, 3'b001, lost);
        send_frame(1, 20, 3'b000, lost);
        send_frame(2, 5, 3'b001, lost);
        chk(lost, "R7 lost pulse for frame without pool", lost, 1);
        @(negedge clk);
        chk(!frame_lost, "R7 lost is one cycle", frame_lost, 0);
        drain(0, 10, 3'b001);
        drain(1, 20, 3'b000);
        no_irq("R7 dropped frame never reported");
        send_frame(3, 7, 3'b101, lost);
        drain(3, 7, 3'b101);

        // R11: frame spills into a busy pool part way through
        send_frame(0, 10, 3'b001, lost);
        send_frame(1, 40, 3'b001, lost);
        chk(lost, "R11 lost pulse for spilled frame", lost, 1);
        drain(0, 10, 3'b001);
        no_irq("R11 partial pool discarded");
        send_frame(2, 3, 3'b011, lost);
        chk(!lost, "R11 reception resumes", lost, 0);
        drain(2, 3, 3'b011);

        // Random frames, each drained before the next
        for (int k = 0; k < 40; k++) begin
            int len;
            logic [2:0] st;
            len = 1 + int'($urandom % 64);
            st  = 3'($urandom);
            if (k % 5 == 0) begin
                ack = 1'b1; @(negedge clk); ack = 1'b0;  // R8 idle ack
            end
            send_frame(k % 4, len, st, lost);
            chk(!lost, "R2 random frame stored", lost, 0);
            drain(k % 4, len, st);
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule